// File: doc/BRIEF.md
# Shared Memory Port Arbiter

This block decides which of two on-chip clients may use one port of a dual-port memory on the logic side of a device. One client, the command receiver, reads incoming commands out of the memory. The other client, the data sender, writes results back into it. Only one of them may drive the port at a time, and this block enforces that rule with a three-state Moore machine: idle, receiving and sending.

A pending-command indication moves the machine from idle into receiving. A send request moves it into sending, but only while no command is pending, so receiving always wins a tie. Each client keeps the port until it raises its own completion flag, and the machine always returns to idle before it grants the port again. While a client holds the grant, its address, and for the sender its write enable and write data, go straight through to the port. While nobody holds it, every port control is driven to zero. Read data from the memory is returned to the receiver only, and only while it holds the grant.

The control and status pins are plain level signals. No data stream crosses this block's edge, so there is no valid/ready handshake and no back-pressure. Each client paces itself through its own completion flag.

Top module: `mem_port_arbiter`

## Requirements
- R1: An active-high synchronous reset puts the machine in idle at the next rising edge, from any state. After that edge both grant outputs are 0 and every port output is 0.
- R2: In idle, `mem_wen`, `mem_addr`, `mem_wdata` and `rx_rdata` are all 0, whatever the values on the client inputs and on `mem_rdata`.
- R3: In idle, `cmd_pending`=1 at a rising edge makes `gnt_rx` equal 1 after that edge.
- R4: While receiving, `mem_addr` equals `rx_addr`, `mem_wen` is 0, `mem_wdata` is 0 and `rx_rdata` equals `mem_rdata`. The sender's inputs have no effect.
- R5: The machine stays in receiving until `rx_done`=1 at a rising edge, and then goes to idle. It goes to idle even when a send request is pending at that edge.
- R6: In idle, `send_req`=1 together with `cmd_pending`=0 at a rising edge enters sending. When both are 1, receiving is entered instead.
- R7: While sending, `mem_wen`, `mem_addr` and `mem_wdata` equal `tx_wen`, `tx_addr` and `tx_wdata`, and `rx_rdata` is 0.
- R8: The machine stays in sending until `tx_done`=1 at a rising edge, and then goes to idle.
- R9: A completion flag that arrives in idle, or while the other client holds the port, is ignored: the state does not change.
- R10: `gnt_rx` is 1 exactly in receiving and `gnt_tx` is 1 exactly in sending. The two are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_pending | input | 1 | An incoming command is waiting to be received |
| send_req | input | 1 | The sender wants the port |
| rx_done | input | 1 | The receiver has finished with the port |
| tx_done | input | 1 | The sender has finished with the port |
| rx_addr | input | ADDR_W | Address requested by the receiver |
| rx_rdata | output | DATA_W | Read data returned to the receiver |
| tx_wen | input | 1 | Write enable from the sender |
| tx_addr | input | ADDR_W | Address requested by the sender |
| tx_wdata | input | DATA_W | Write data from the sender |
| mem_wen | output | 1 | Write enable to the memory port |
| mem_addr | output | ADDR_W | Read/write address to the memory port |
| mem_wdata | output | DATA_W | Write data to the memory port |
| mem_rdata | input | DATA_W | Read data from the memory port |
| gnt_rx | output | 1 | The receiver owns the port |
| gnt_tx | output | 1 | The sender owns the port |

## Verification
Two situations are hard to reach from the ports. The first is a finished receive with a send request already waiting: the request must not take effect until one idle cycle has passed. The stimulus holds `send_req` high for the whole receive and then raises `rx_done`. The second is stray completion flags. Here the bench raises the other client's completion flag, and both flags in idle, while the client inputs and `mem_rdata` carry nonzero patterns. It then checks the grants and the port outputs on the following cycle to confirm that nothing moved.

// File: rtl/arb_pkg.sv
package arb_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RECV = 2'd1,
    ST_SEND = 2'd2
  } arb_state_e;

endpackage

// File: rtl/arb_ctrl.sv
module arb_ctrl
  import arb_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic cmd_pending,
  input  logic send_req,
  input  logic rx_done,
  input  logic tx_done,
  output logic gnt_rx,
  output logic gnt_tx
);

  arb_state_e state_q;
  arb_state_e state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (cmd_pending)   state_d = ST_RECV;
        else if (send_req) state_d = ST_SEND;
      end
      ST_RECV: if (rx_done) state_d = ST_IDLE;
      ST_SEND: if (tx_done) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_IDLE;
    else     state_q <= state_d;
  end

  // Moore decode: grants come from the state register alone
  assign gnt_rx = (state_q == ST_RECV);
  assign gnt_tx = (state_q == ST_SEND);

  AST_IDLE_TO_RECV: assert property (@(posedge clk) disable iff (rst)
    (!gnt_rx && !gnt_tx && cmd_pending) |=> gnt_rx); // R3
  AST_RECV_HOLD: assert property (@(posedge clk) disable iff (rst)
    (gnt_rx && !rx_done) |=> gnt_rx); // R5
  AST_RECV_EXIT: assert property (@(posedge clk) disable iff (rst)
    (gnt_rx && rx_done) |=> (!gnt_rx && !gnt_tx)); // R5
  AST_SEND_ENTRY: assert property (@(posedge clk) disable iff (rst)
    (!gnt_rx && !gnt_tx && send_req && !cmd_pending) |=> gnt_tx); // R6
  AST_SEND_HOLD: assert property (@(posedge clk) disable iff (rst)
    (gnt_tx && !tx_done) |=> gnt_tx); // R8
  AST_SEND_EXIT: assert property (@(posedge clk) disable iff (rst)
    (gnt_tx && tx_done) |=> (!gnt_rx && !gnt_tx)); // R8
  AST_IDLE_STAY: assert property (@(posedge clk) disable iff (rst)
    (!gnt_rx && !gnt_tx && !cmd_pending && !send_req) |=> (!gnt_rx && !gnt_tx)); // R9
  AST_GNT_EXCL: assert property (@(posedge clk) disable iff (rst)
    $onehot0({gnt_rx, gnt_tx})); // R10

endmodule

// File: rtl/arb_gate.sv
module arb_gate #(
  parameter int W = 8
) (
  input  logic         en,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign dout[i] = en & din[i];
  end

endmodule

// File: rtl/arb_port_mux.sv
module arb_port_mux #(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              gnt_rx,
  input  logic              gnt_tx,
  input  logic [ADDR_W-1:0] rx_addr,
  output logic [DATA_W-1:0] rx_rdata,
  input  logic              tx_wen,
  input  logic [ADDR_W-1:0] tx_addr,
  input  logic [DATA_W-1:0] tx_wdata,
  output logic              mem_wen,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata
);

  logic [ADDR_W-1:0] addr_from_rx;
  logic [ADDR_W-1:0] addr_from_tx;

  arb_gate #(.W(ADDR_W)) u_addr_rx (.en(gnt_rx), .din(rx_addr),   .dout(addr_from_rx));
  arb_gate #(.W(ADDR_W)) u_addr_tx (.en(gnt_tx), .din(tx_addr),   .dout(addr_from_tx));
  arb_gate #(.W(1))      u_wen     (.en(gnt_tx), .din(tx_wen),    .dout(mem_wen));
  arb_gate #(.W(DATA_W)) u_wdata   (.en(gnt_tx), .din(tx_wdata),  .dout(mem_wdata));
  arb_gate #(.W(DATA_W)) u_rdata   (.en(gnt_rx), .din(mem_rdata), .dout(rx_rdata));

  // grants are exclusive, so OR-ing the two gated addresses selects one
  assign mem_addr = addr_from_rx | addr_from_tx;

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!gnt_rx && !gnt_tx) |-> (!mem_wen && mem_addr == '0 && mem_wdata == '0 && rx_rdata == '0)); // R2
  AST_RECV_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    gnt_rx |-> (!mem_wen && mem_wdata == '0 && mem_addr == rx_addr)); // R4
  AST_SEND_PASS: assert property (@(posedge clk) disable iff (rst)
    gnt_tx |-> (mem_wen == tx_wen && mem_addr == tx_addr && rx_rdata == '0)); // R7

endmodule

// File: rtl/mem_port_arbiter.sv
module mem_port_arbiter #(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_pending,
  input  logic              send_req,
  input  logic              rx_done,
  input  logic              tx_done,
  input  logic [ADDR_W-1:0] rx_addr,
  output logic [DATA_W-1:0] rx_rdata,
  input  logic              tx_wen,
  input  logic [ADDR_W-1:0] tx_addr,
  input  logic [DATA_W-1:0] tx_wdata,
  output logic              mem_wen,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              gnt_rx,
  output logic              gnt_tx
);

  arb_ctrl u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .cmd_pending (cmd_pending),
    .send_req    (send_req),
    .rx_done     (rx_done),
    .tx_done     (tx_done),
    .gnt_rx      (gnt_rx),
    .gnt_tx      (gnt_tx)
  );

  arb_port_mux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mux (
    .clk       (clk),
    .rst       (rst),
    .gnt_rx    (gnt_rx),
    .gnt_tx    (gnt_tx),
    .rx_addr   (rx_addr),
    .rx_rdata  (rx_rdata),
    .tx_wen    (tx_wen),
    .tx_addr   (tx_addr),
    .tx_wdata  (tx_wdata),
    .mem_wen   (mem_wen),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata)
  );

endmodule

// File: tb/sim_mem_port_arbiter.sv
`timescale 1ns/1ps
module sim_mem_port_arbiter;
  localparam int AW = 13;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst;
  logic cmd_pending, send_req, rx_done, tx_done, tx_wen;
  logic [AW-1:0] rx_addr, tx_addr, mem_addr;
  logic [DW-1:0] rx_rdata, tx_wdata, mem_wdata, mem_rdata;
  logic mem_wen, gnt_rx, gnt_tx;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  mem_port_arbiter #(.ADDR_W(AW), .DATA_W(DW)) u0 (
    .clk(clk), .rst(rst), .cmd_pending(cmd_pending), .send_req(send_req),
    .rx_done(rx_done), .tx_done(tx_done), .rx_addr(rx_addr), .rx_rdata(rx_rdata),
    .tx_wen(tx_wen), .tx_addr(tx_addr), .tx_wdata(tx_wdata), .mem_wen(mem_wen),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .gnt_rx(gnt_rx), .gnt_tx(gnt_tx)
  );

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  // advance one edge, then sample 1 ns later
  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk_quiet(input string tag);
    chk({tag, " grants"}, {gnt_rx, gnt_tx}, 2'b00);
    chk({tag, " mem_wen"}, mem_wen, 0);
    chk({tag, " mem_addr"}, mem_addr, 0);
    chk({tag, " mem_wdata"}, mem_wdata, 0);
    chk({tag, " rx_rdata"}, rx_rdata, 0);
  endtask

  task automatic t_reset();
    rst = 1; cmd_pending = 1; send_req = 1; rx_done = 0; tx_done = 0;
    tx_wen = 1; rx_addr = 13'h1A5; tx_addr = 13'h0F3;
    tx_wdata = 32'hDEAD_BEEF; mem_rdata = 32'h1234_5678;
    step();
    chk_quiet("R1 reset");
    cmd_pending = 0; send_req = 0;
    rst = 0;
  endtask

  task automatic t_idle_ignore();
    step();
    chk_quiet("R2 idle");
    rx_done = 1; tx_done = 1;
    step();
    chk_quiet("R9 done flags in idle");
    rx_done = 0; tx_done = 0;
  endtask

  task automatic t_receive();
    cmd_pending = 1;
    step();
    chk("R3 gnt_rx", gnt_rx, 1);
    chk("R10 gnt_tx in recv", gnt_tx, 0);
    cmd_pending = 0; send_req = 1;
    chk("R4 addr", mem_addr, 64'(rx_addr));
    chk("R4 no write", mem_wen, 0);
    chk("R4 wdata", mem_wdata, 0);
    chk("R4 rdata", rx_rdata, 64'(mem_rdata));
    rx_addr = 13'h1FFF; mem_rdata = 32'hCAFE_0001; tx_done = 1;
    #1;
    chk("R4 addr follows", mem_addr, 64'h1FFF);
    chk("R4 rdata follows", rx_rdata, 64'hCAFE_0001);
    step();
    chk("R9 tx_done in recv", gnt_rx, 1);
    tx_done = 0;
    step();
    chk("R5 hold", gnt_rx, 1);
    rx_done = 1;
    step();
    rx_done = 0;
    chk_quiet("R5 idle before send");
    step();
    chk("R6 send entered", gnt_tx, 1);
    send_req = 0;
    tx_done = 1;
    step();
    tx_done = 0;
    chk_quiet("R8 exit");
  endtask

  task automatic t_priority();
    cmd_pending = 1; send_req = 1;
    step();
    chk("R6 priority grants", {gnt_rx, gnt_tx}, 2'b10);
    cmd_pending = 0; send_req = 0; rx_done = 1;
    step();
    rx_done = 0;
    chk_quiet("R5 exit");
  endtask

  task automatic t_send();
    send_req = 1;
    step();
    chk("R6 gnt_tx", {gnt_rx, gnt_tx}, 2'b01);
    send_req = 0;
    tx_wen = 1; tx_addr = 13'h0ABC; tx_wdata = 32'h0BAD_F00D; mem_rdata = 32'h7777_7777;
    #1;
    chk("R7 wen", mem_wen, 1);
    chk("R7 addr", mem_addr, 64'h0ABC);
    chk("R7 wdata", mem_wdata, 64'h0BAD_F00D);
    chk("R7 rdata blocked", rx_rdata, 0);
    tx_wen = 0;
    #1;
    chk("R7 wen low", mem_wen, 0);
    rx_done = 1; cmd_pending = 1;
    step();
    chk("R9 rx_done in send", gnt_tx, 1);
    chk("R8 hold with cmd", gnt_rx, 0);
    rx_done = 0; cmd_pending = 0;
    step();
    chk("R8 hold", gnt_tx, 1);
    tx_done = 1;
    step();
    tx_done = 0;
    chk_quiet("R8 back to idle");
  endtask

  task automatic t_reset_mid();
    send_req = 1;
    step();
    send_req = 0;
    chk("R1 pre gnt_tx", gnt_tx, 1);
    rst = 1;
    step();
    rst = 0;
    chk_quiet("R1 reset from send");
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_idle_ignore();
        t_receive();
        t_priority();
        t_send();
        t_reset_mid();
      end
      begin
        repeat (2000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule